// File: doc/BRIEF.md
# EDO DRAM Command Sequencer

This block sits between a synchronous host port and an asynchronous extended-data-out DRAM with a 16-bit data path. Each host request carries a 24-bit word address, a write flag, two byte enables and write data. The sequencer splits the address into a row half and a column half on a 12-bit multiplexed bus. It strobes the row with RAS and the column with per-byte CAS strobes. It returns read data with a one-clock completion pulse. Every timing interval is a parameter counted in controller clocks.

Writes use early-write timing. W goes low before any CAS strobe falls, so the memory never turns its data pins around during a write. The controller drives the data bus only for a short window around the column strobe. Reads hold OE low and W high across the whole column phase. The read word is registered on the last clock of the CAS-low window, while the memory is still driving.

Refresh is requested by an external scheduler through a request/grant pair. When the request is seen, the controller first completes any access in flight and its precharge. It then runs a CAS-before-RAS cycle and holds the grant high for the length of that cycle.

Top module: `edo_seq_ctrl`

## Requirements
- R1: Host address bits [23:12] appear on `dram_a` as the row when RAS falls, and bits [11:0] as the column when CAS falls. A read returns the word last written to that address.
- R2: In a write, `dram_we_n` is already low and unchanged on the clock where a CAS strobe falls, and `dram_oe_n` stays high while `dram_we_n` is low.
- R3: `dram_ucas_n` (bits 15:8) falls in an access only when `host_be[1]` is 1, and `dram_lcas_n` (bits 7:0) only when `host_be[0]` is 1. A write with `host_be` = 00 leaves memory unchanged.
- R4: RAS stays low for at least `T_RAS` clocks and for fewer than `T_RAS_MAX` clocks.
- R5: RAS stays high for at least `T_RP` clocks between two low periods.
- R6: In a host access, CAS falls exactly `T_RCD` clocks after RAS falls. The address bus changes at most once while RAS is low and both CAS strobes are high.
- R7: In a read, `dram_oe_n` is low and `dram_we_n` is high on the first clock with CAS low and on the first clock after CAS rises.
- R8: Read data is registered on the last CAS-low clock. `host_done` is high for exactly one clock, and `host_rdata` is valid on that clock.
- R9: A refresh request seen while idle wins over a simultaneous host request. A refresh request raised during an access is served only after that access completes. Refresh pulls both CAS strobes low before RAS falls, keeps W high, and holds `ref_gnt` high throughout.
- R10: The controller drives `dram_dq` only during writes, from RAS fall until `T_DH` clocks after CAS fall. The write word is present on the bus when CAS falls.
- R11: While `rst_n` is low, RAS, both CAS strobes, W and OE are high, and `host_done` and `ref_gnt` are low. Assertion of reset takes effect without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until `host_done` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_be | input | 2 | Byte enables, bit 1 = upper byte |
| host_addr | input | 24 | Word address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with `host_done` |
| host_done | output | 1 | One-clock completion pulse |
| ref_req | input | 1 | Refresh request from scheduler |
| ref_gnt | output | 1 | High while a refresh cycle runs |
| dram_a | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write control, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
The assertions assume that the host holds `host_req` and its address, data and enables steady until `host_done`, and drops the request on that pulse. They also assume that the scheduler releases `ref_req` once it sees `ref_gnt`, so that no second refresh starts by accident. The bench keeps to both rules: it drives inputs only on falling clock edges, releases each request on the sample where the matching response appears, and relies on a memory model that drives the bus only when OE is low after a read column strobe.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_HOLD = 3'd3,
    ST_PRE  = 3'd4,
    ST_RFC  = 3'd5,
    ST_RFR  = 3'd6
  } edo_st_e;
endpackage

// File: rtl/edo_down_cnt.sv
module edo_down_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)
      cnt_d = load_val;
    else if (cnt != '0)
      cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/edo_ras_timer.sv
module edo_ras_timer #(
  parameter int W     = 8,
  parameter int LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_low,
  output logic reached
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!ras_low)
      cnt_d = '0;
    else if (cnt_q != {W{1'b1}})
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign reached = (int'(cnt_q) >= LIMIT - 1);
endmodule

// File: rtl/edo_dq_io.sv
module edo_dq_io #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  inout  wire  [DW-1:0] dq,
  output logic [DW-1:0] rdata
);
  assign dq = drive ? wdata : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= dq;
  end
endmodule

// File: rtl/edo_seq_ctrl.sv
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MUX_W     = 12,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_RAS     = 7,
  parameter int T_RAS_MAX = 1250,
  parameter int T_RP      = 5,
  parameter int T_DH      = 2,
  parameter int T_CSR     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [1:0]        host_be,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  input  logic              ref_req,
  output logic              ref_gnt,
  output logic [MUX_W-1:0]  dram_a,
  output logic              dram_ras_n,
  output logic              dram_ucas_n,
  output logic              dram_lcas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  inout  wire  [DATA_W-1:0] dram_dq
);
  localparam int LANES = 2;
  localparam int T_SUM = T_RCD + T_CAS + T_RAS + T_RP + T_CSR;
  localparam int CNT_W = $clog2(T_SUM + 1);
  localparam int RT_W  = $clog2(T_RAS_MAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_s <= rs_meta;
    end
  end

  edo_st_e             st_q, st_d;
  logic                we_q;
  logic [LANES-1:0]    be_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                done_q, done_d;
  logic                acc_ld, cnt_ld, cap;
  logic [CNT_W-1:0]    cnt_q, cnt_val;
  logic                cnt_zero, ras_ok, dq_drive;
  logic                row_ph, col_ph, hold_ph, rf_cas_ph, rf_ras_ph;
  logic [LANES-1:0]    cas_n;

  assign row_ph    = (st_q == ST_ROW);
  assign col_ph    = (st_q == ST_COL);
  assign hold_ph   = (st_q == ST_HOLD);
  assign rf_cas_ph = (st_q == ST_RFC);
  assign rf_ras_ph = (st_q == ST_RFR);

  edo_down_cnt #(.W(CNT_W)) u_phase_cnt (
    .clk(clk), .rst_n(rst_n_s), .load(cnt_ld), .load_val(cnt_val),
    .cnt(cnt_q), .zero(cnt_zero)
  );

  edo_ras_timer #(.W(RT_W), .LIMIT(T_RAS)) u_ras_timer (
    .clk(clk), .rst_n(rst_n_s), .ras_low(~dram_ras_n), .reached(ras_ok)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_ld  = 1'b0;
    cnt_val = '0;
    acc_ld  = 1'b0;
    done_d  = 1'b0;
    cap     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_req) begin
          st_d    = ST_RFC;
          cnt_ld  = 1'b1;
          cnt_val = CNT_W'(T_CSR - 1);
        end else if (host_req) begin
          st_d    = ST_ROW;
          acc_ld  = 1'b1;
          cnt_ld  = 1'b1;
          cnt_val = CNT_W'(T_RCD - 1);
        end
      end
      ST_ROW: if (cnt_zero) begin
        st_d    = ST_COL;
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(T_CAS - 1);
      end
      ST_COL: if (cnt_zero) begin
        st_d   = ST_HOLD;
        done_d = 1'b1;
        cap    = ~we_q;
      end
      ST_HOLD: if (ras_ok) begin
        st_d    = ST_PRE;
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(T_RP - 1);
      end
      ST_PRE: if (cnt_zero) st_d = ST_IDLE;
      ST_RFC: if (cnt_zero) begin
        st_d    = ST_RFR;
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(T_RAS - 1);
      end
      ST_RFR: if (cnt_zero) begin
        st_d    = ST_PRE;
        cnt_ld  = 1'b1;
        cnt_val = CNT_W'(T_RP - 1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (acc_ld) begin
        we_q    <= host_we;
        be_q    <= host_be;
        addr_q  <= host_addr;
        wdata_q <= host_wdata;
      end
    end
  end

  // strobe decode
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign cas_n[g] = ~((col_ph & be_q[g]) | rf_cas_ph | rf_ras_ph);
    end
  endgenerate

  assign dram_lcas_n = cas_n[0];
  assign dram_ucas_n = cas_n[LANES-1];
  assign dram_ras_n  = ~(row_ph | col_ph | hold_ph | rf_ras_ph);
  assign dram_we_n   = ~(we_q & (row_ph | col_ph | hold_ph));
  assign dram_oe_n   = ~(~we_q & (row_ph | col_ph | hold_ph));
  assign dram_a      = ((row_ph & ~cnt_zero) | ~(row_ph | col_ph | hold_ph))
                       ? addr_q[ADDR_W-1:MUX_W] : addr_q[MUX_W-1:0];
  assign dq_drive    = we_q & (row_ph | (col_ph & (int'(cnt_q) >= T_CAS - T_DH)));
  assign ref_gnt     = rf_cas_ph | rf_ras_ph;
  assign host_done   = done_q;

  edo_dq_io #(.DW(DATA_W)) u_dq (
    .clk(clk), .rst_n(rst_n_s), .drive(dq_drive), .wdata(wdata_q),
    .capture(cap), .dq(dram_dq), .rdata(host_rdata)
  );
endmodule

// File: rtl/edo_seq_ctrl_chk.sv
module edo_seq_ctrl_chk #(
  parameter int MUX_W     = 12,
  parameter int T_RAS     = 7,
  parameter int T_RAS_MAX = 1250,
  parameter int T_RP      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             ucas_n,
  input logic             lcas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [MUX_W-1:0] a,
  input logic             dq_drive,
  input logic [1:0]       be_q,
  input logic             ref_gnt,
  input logic             host_done
);
  logic [31:0]      low_run, high_run, chg;
  logic [MUX_W-1:0] a_prev;
  logic             win_prev;
  logic             in_win;

  assign in_win = ~ras_n & ucas_n & lcas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= 32'(T_RP);
      chg      <= '0;
      a_prev   <= '0;
      win_prev <= 1'b0;
    end else begin
      low_run  <= ras_n ? '0 : low_run + 1;
      high_run <= ras_n ? high_run + 1 : '0;
      a_prev   <= a;
      win_prev <= in_win;
      if (!in_win)                                chg <= '0;
      else if (win_prev && (a != a_prev))         chg <= chg + 1;
    end
  end

  assert_ras_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_run >= 32'(T_RAS)));
  assert_ras_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run < 32'(T_RAS_MAX)));
  assert_pre_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_run >= 32'(T_RP)));
  assert_col_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chg <= 32'd1));
  assert_cas_under_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ucas_n) || $fell(lcas_n)) && !ref_gnt) |-> !ras_n);
  assert_we_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ucas_n) || $fell(lcas_n)) && !ras_n) |-> $stable(we_n));
  assert_oe_off_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_read_we_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n);
  assert_upper_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ucas_n) && !ras_n) |-> be_q[1]);
  assert_lower_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcas_n) && !ras_n) |-> be_q[0]);
  assert_cbr_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gnt && $fell(ras_n)) |-> (!ucas_n && !lcas_n && we_n));
  assert_dq_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !we_n);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
endmodule

bind edo_seq_ctrl edo_seq_ctrl_chk #(
  .MUX_W(MUX_W), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .ucas_n(dram_ucas_n),
  .lcas_n(dram_lcas_n), .we_n(dram_we_n), .oe_n(dram_oe_n), .a(dram_a),
  .dq_drive(dq_drive), .be_q(be_q), .ref_gnt(ref_gnt), .host_done(host_done)
);

// File: tb/sim_edo_seq_ctrl.sv
module sim_edo_seq_ctrl;
  localparam int T_RCD = 3;
  localparam int T_RAS = 7;
  localparam int T_RP  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, host_req, host_we, ref_req;
  logic [1:0]  host_be;
  logic [23:0] host_addr;
  logic [15:0] host_wdata;
  wire  [15:0] host_rdata;
  wire         host_done, ref_gnt, dram_ras_n, dram_ucas_n, dram_lcas_n;
  wire         dram_we_n, dram_oe_n;
  wire  [11:0] dram_a;
  wire  [15:0] dram_dq;

  edo_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_be(host_be), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_done(host_done), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .dram_a(dram_a), .dram_ras_n(dram_ras_n),
    .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq(dram_dq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: 256 words indexed by low row and column nibbles
  logic [15:0] mem [0:255];
  logic [11:0] m_row, m_col;
  logic        rd_act = 1'b0;
  int          ref_seen = 0;

  always @(negedge dram_ras_n) begin
    #1;
    m_row = dram_a;
    if (!dram_ucas_n && !dram_lcas_n) ref_seen++;
  end

  always @(negedge dram_lcas_n or negedge dram_ucas_n or posedge dram_ras_n) begin
    #1;
    if (dram_ras_n) rd_act = 1'b0;
    else begin
      m_col = dram_a;
      if (!dram_we_n) begin
        if (!dram_lcas_n) mem[{m_row[3:0], m_col[3:0]}][7:0]  = dram_dq[7:0];
        if (!dram_ucas_n) mem[{m_row[3:0], m_col[3:0]}][15:8] = dram_dq[15:8];
      end else rd_act = 1'b1;
    end
  end

  assign dram_dq = (rd_act && !dram_oe_n) ? mem[{m_row[3:0], m_col[3:0]}] : 16'hzzzz;

  // port monitor
  logic        cur_we;
  logic [15:0] cur_wd;
  logic        seen_cas, hold_chk, u_seen, l_seen, prev_ras;
  int          lr, hr;

  always @(negedge clk) begin
    if (!rst_n) begin
      lr = 0; hr = 1000; prev_ras = 1'b1;
    end else begin
      if (!dram_ras_n) begin
        if (prev_ras) chk(hr >= T_RP, "R5 precharge", hr, T_RP);
        if (!ref_gnt && !seen_cas && (!dram_ucas_n || !dram_lcas_n)) begin
          seen_cas = 1'b1;
          chk(lr == T_RCD, "R6 ras-to-cas", lr, T_RCD);
          if (cur_we) begin
            chk(dram_dq == cur_wd, "R10 write data on bus", dram_dq, cur_wd);
            chk(!dram_we_n && dram_oe_n, "R2 early write", {dram_we_n, dram_oe_n}, 2'b01);
          end else
            chk(!dram_oe_n && dram_we_n, "R7 read at cas fall", {dram_we_n, dram_oe_n}, 2'b10);
        end
        if (!ref_gnt && !cur_we && seen_cas && !hold_chk && dram_ucas_n && dram_lcas_n) begin
          hold_chk = 1'b1;
          chk(!dram_oe_n && dram_we_n, "R7 read after cas rise", {dram_we_n, dram_oe_n}, 2'b10);
        end
        if (!dram_ucas_n) u_seen = 1'b1;
        if (!dram_lcas_n) l_seen = 1'b1;
        lr++; hr = 0;
      end else begin
        if (!prev_ras) chk(lr >= T_RAS, "R4 ras width", lr, T_RAS);
        hr++; lr = 0;
      end
      prev_ras = dram_ras_n;
    end
  end

  task automatic start_access(input logic we, input logic [1:0] be,
                              input logic [23:0] addr, input logic [15:0] wd);
    cur_we = we; cur_wd = wd;
    seen_cas = 1'b0; hold_chk = 1'b0; u_seen = 1'b0; l_seen = 1'b0;
    host_we = we; host_be = be; host_addr = addr; host_wdata = wd;
    host_req = 1'b1;
  endtask

  task automatic do_access(input logic we, input logic [1:0] be,
                           input logic [23:0] addr, input logic [15:0] wd,
                           input logic [15:0] exp);
    bit got = 1'b0;
    @(negedge clk);
    start_access(we, be, addr, wd);
    for (int t = 0; t < 200 && !got; t++) begin
      @(negedge clk);
      if (host_done) got = 1'b1;
    end
    host_req = 1'b0;
    chk(got, "R8 done seen", got, 1);
    chk({u_seen, l_seen} == be, "R3 lane strobes", {u_seen, l_seen}, be);
    if (!we && got) begin
      chk(host_rdata == exp, "R1 R8 read data", host_rdata, exp);
      chk(m_row == addr[23:12], "R1 row half", m_row, addr[23:12]);
      chk(m_col == addr[11:0], "R1 column half", m_col, addr[11:0]);
    end
    @(negedge clk);
    chk(!host_done, "R8 single pulse", host_done, 0);
  endtask

  // {we, be, addr, wdata, expected read}
  localparam logic [58:0] VEC [0:11] = '{
    {1'b1, 2'b11, 24'h001002, 16'hA1B2, 16'h0000},
    {1'b1, 2'b11, 24'h003004, 16'hC3D4, 16'h0000},
    {1'b0, 2'b11, 24'h001002, 16'h0000, 16'hA1B2},
    {1'b1, 2'b01, 24'h001002, 16'hFFEE, 16'h0000},
    {1'b1, 2'b10, 24'h003004, 16'h5566, 16'h0000},
    {1'b0, 2'b11, 24'h001002, 16'h0000, 16'hA1EE},
    {1'b0, 2'b11, 24'h003004, 16'h0000, 16'h55D4},
    {1'b1, 2'b00, 24'h001002, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 24'h001002, 16'h0000, 16'hA1EE},
    {1'b1, 2'b11, 24'hFFFFFF, 16'h1234, 16'h0000},
    {1'b0, 2'b11, 24'hFFFFFF, 16'h0000, 16'h1234},
    {1'b0, 2'b11, 24'h003004, 16'h0000, 16'h55D4}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit g_seen, d_seen, g_first, d_first;
    int r0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_be = 2'b00;
    host_addr = '0; host_wdata = '0; ref_req = 1'b0;
    cur_we = 1'b0; cur_wd = '0;
    seen_cas = 1'b0; hold_chk = 1'b0; u_seen = 1'b0; l_seen = 1'b0;
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'b11111,
        "R11 strobes idle in reset", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n}, 5'b11111);
    chk(!host_done && !ref_gnt, "R11 done and grant low", {host_done, ref_gnt}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 12; i++)
      do_access(VEC[i][58], VEC[i][57:56], VEC[i][55:32], VEC[i][31:16], VEC[i][15:0]);

    // R9: refresh while idle
    r0 = ref_seen;
    @(negedge clk); ref_req = 1'b1;
    g_seen = 1'b0;
    for (int t = 0; t < 100 && !g_seen; t++) begin
      @(negedge clk);
      if (ref_gnt) g_seen = 1'b1;
    end
    ref_req = 1'b0;
    for (int t = 0; t < 100 && ref_gnt; t++) @(negedge clk);
    chk(g_seen, "R9 grant given", g_seen, 1);
    repeat (2) @(negedge clk);
    chk(ref_seen == r0 + 1, "R9 cas-before-ras cycle", ref_seen, r0 + 1);

    // R9: simultaneous refresh and host read, refresh wins
    repeat (8) @(negedge clk);
    ref_req = 1'b1;
    start_access(1'b0, 2'b11, 24'h003004, 16'h0000);
    g_seen = 1'b0; d_seen = 1'b0; g_first = 1'b0;
    for (int t = 0; t < 200 && !d_seen; t++) begin
      @(negedge clk);
      if (ref_gnt && !g_seen) begin g_seen = 1'b1; g_first = !d_seen; ref_req = 1'b0; end
      if (host_done) begin d_seen = 1'b1; host_req = 1'b0;
        chk(host_rdata == 16'h55D4, "R8 read after refresh", host_rdata, 16'h55D4); end
    end
    chk(g_first, "R9 refresh priority", g_first, 1);

    // R9: refresh raised during an access waits for it
    repeat (10) @(negedge clk);
    start_access(1'b0, 2'b11, 24'h001002, 16'h0000);
    g_seen = 1'b0; d_seen = 1'b0; d_first = 1'b0;
    for (int t = 0; t < 300 && !(g_seen && d_seen); t++) begin
      @(negedge clk);
      if (t == 2) ref_req = 1'b1;
      if (host_done && !d_seen) begin d_seen = 1'b1; d_first = !g_seen; host_req = 1'b0;
        chk(host_rdata == 16'hA1EE, "R1 read under refresh", host_rdata, 16'hA1EE); end
      if (ref_gnt && !g_seen) begin g_seen = 1'b1; ref_req = 1'b0; end
    end
    chk(d_first && g_seen, "R9 access finishes first", {d_first, g_seen}, 2'b11);
    for (int t = 0; t < 100 && ref_gnt; t++) @(negedge clk);

    // R11: reset in the middle of an access
    repeat (8) @(negedge clk);
    start_access(1'b1, 2'b11, 24'h005006, 16'h7777);
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(dram_ras_n && dram_ucas_n && dram_lcas_n && dram_we_n,
        "R11 async strobe release", {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n}, 4'hF);
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_access(1'b0, 2'b11, 24'h001002, 16'h0000, 16'hA1EE);
    repeat (10) @(negedge clk);
    summary();
  end
endmodule